// File: doc/BRIEF.md
# Programmable Sum-of-Products Array with Output Inversion

This block is a small programmable logic array. Three data inputs feed four product terms. Each term can pick up every input in true form, in inverted form, or not at all. A second programmable plane lets any product term drive any output, so one term can serve several outputs at no extra cost. Each output then passes through an XOR stage whose second input is a stored polarity bit. With this stage an output can carry either a sum of products or its complement.

The whole configuration lives in one shift register that loads one bit per clock. While the load enable is low the configuration holds. The data path from the input bus to the output bus is purely combinational. A function pair whose minimised forms need more than four distinct terms can still fit if one output is built as the inverse of a shared set of terms.

Top module: `pla_core`

## Requirements
- R1: Reset (synchronous, active high `rst`) clears every configuration bit, so after reset every output is 0 for all eight input codes.
- R2: The configuration is `34` bits long and is shifted in one bit per clock while `cfg_shift_en` is high. The first bit sent lands at index 0 and the last at index 33. Indices 0..23 form the AND plane at `t*6 + 2*i + s`, where t is the term, i the input and s is 0 for the true literal and 1 for the complemented literal. Indices 24..31 form the OR plane at `24 + o*4 + t`. Indices 32..33 hold the polarity bits at `32 + o`.
- R3: While `cfg_shift_en` is low the configuration and hence the input-to-output mapping stay unchanged, whatever `cfg_bit` does.
- R4: A product term is the AND of its connected literals: a set true bit requires `din[i]`=1 and a set complement bit requires `din[i]`=0. A term that connects both forms of one input is always 0.
- R5: A product term with no connected literals evaluates to 0.
- R6: Each output, before inversion, is the OR of the product terms connected to it, and any term may be connected to several outputs at once.
- R7: An output with no connected product terms is 0 before inversion, so it shows its polarity bit.
- R8: A polarity bit of 0 passes the OR result unchanged and a polarity bit of 1 inverts it.
- R9: The outputs follow `din` combinationally, with no register between the input bus and the output bus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the configuration register |
| rst | input | 1 | Synchronous active-high reset, clears the configuration |
| cfg_shift_en | input | 1 | When high, one configuration bit is shifted in per clock |
| cfg_bit | input | 1 | Serial configuration data |
| din | input | 3 | Logic inputs to the array |
| dout | output | 2 | Array outputs after the polarity stage |

## Verification
The bench goes after the corners where a plausible mistake changes the output. It tests an empty product term, which a naive AND-reduce would turn into a constant 1. It tests an empty output with inversion set, which must read 1. It tests a term that holds both forms of one input, and it checks that the load order puts the first shifted bit at term 0, input 0, true literal. A reversed shift direction or a swapped true/complement pair would scramble every such directed case.

A parity function and its complement, which share all four terms, show that the OR plane really shares terms and that the XOR stage inverts. The bench also checks that the mapping holds while the enable is low, and that reset returns all outputs to 0. Seeded random configurations then cover the planes broadly against a bench model.

// File: rtl/pla_pkg.sv
package pla_pkg;

   // Selects which literal form a configuration bit controls.
   typedef enum logic {
      LIT_TRUE = 1'b0,
      LIT_COMP = 1'b1
   } lit_sel_e;

   // Number of AND-plane bits: two literal selects per input per term.
   function automatic int and_bits(input int n_in, input int n_term);
      return n_in * 2 * n_term;
   endfunction

   // Number of OR-plane bits: one per (output, term) pair.
   function automatic int or_bits(input int n_term, input int n_out);
      return n_term * n_out;
   endfunction

   // Full configuration length including polarity bits.
   function automatic int cfg_len(input int n_in, input int n_term, input int n_out);
      return and_bits(n_in, n_term) + or_bits(n_term, n_out) + n_out;
   endfunction

   // Position of one literal select bit inside the AND plane.
   function automatic int and_index(input int n_in, input int t, input int i, input lit_sel_e s);
      return t * 2 * n_in + 2 * i + int'(s);
   endfunction

   // Position of one connection bit inside the OR plane (output-major).
   function automatic int or_index(input int n_term, input int o, input int t);
      return o * n_term + t;
   endfunction

endpackage

// File: rtl/pla_cfg_shift.sv
module pla_cfg_shift #(
   parameter int LEN = 34
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           shift_en,
   input  logic           bit_in,
   output logic [LEN-1:0] cfg_q
);

   if (LEN < 2) begin : g_len_bad
      $error("pla_cfg_shift: LEN must be at least 2");
   end

   // New bits enter at the top and move toward index 0, so the first bit
   // sent ends at index 0 after LEN shifts.
   always_ff @(posedge clk) begin
      if (rst) begin
         cfg_q <= '0;
      end else if (shift_en) begin
         cfg_q <= {bit_in, cfg_q[LEN-1:1]};
      end
   end

endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane
   import pla_pkg::*;
#(
   parameter int N_IN   = 3,
   parameter int N_TERM = 4,
   parameter int AW     = 24
) (
   input  logic [N_IN-1:0]   x,
   input  logic [AW-1:0]     and_cfg,
   output logic [N_TERM-1:0] term
);

   localparam int LW = 2 * N_IN;

   if (AW != and_bits(N_IN, N_TERM)) begin : g_aw_bad
      $error("pla_and_plane: AW does not match N_IN and N_TERM");
   end

   for (genvar t = 0; t < N_TERM; t++) begin : g_term
      logic [LW-1:0] lit;
      logic [LW-1:0] sel;

      for (genvar i = 0; i < N_IN; i++) begin : g_lit
         assign lit[2*i + int'(LIT_TRUE)] = x[i];
         assign lit[2*i + int'(LIT_COMP)] = ~x[i];
         assign sel[2*i + int'(LIT_TRUE)] = and_cfg[and_index(N_IN, t, i, LIT_TRUE)];
         assign sel[2*i + int'(LIT_COMP)] = and_cfg[and_index(N_IN, t, i, LIT_COMP)];
      end

      // Unselected literals are forced to 1; an empty term is forced to 0.
      assign term[t] = (|sel) & (&(lit | ~sel));
   end

endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane
   import pla_pkg::*;
#(
   parameter int N_TERM = 4,
   parameter int N_OUT  = 2,
   parameter int OW     = 8
) (
   input  logic [N_TERM-1:0] term,
   input  logic [OW-1:0]     or_cfg,
   output logic [N_OUT-1:0]  sum
);

   if (OW != or_bits(N_TERM, N_OUT)) begin : g_ow_bad
      $error("pla_or_plane: OW does not match N_TERM and N_OUT");
   end

   for (genvar o = 0; o < N_OUT; o++) begin : g_out
      logic [N_TERM-1:0] conn;
      for (genvar t = 0; t < N_TERM; t++) begin : g_conn
         assign conn[t] = or_cfg[or_index(N_TERM, o, t)] & term[t];
      end
      assign sum[o] = |conn;
   end

endmodule

// File: rtl/pla_pol_stage.sv
module pla_pol_stage #(
   parameter int N_OUT = 2
) (
   input  logic [N_OUT-1:0] sum,
   input  logic [N_OUT-1:0] pol,
   output logic [N_OUT-1:0] dout
);

   for (genvar o = 0; o < N_OUT; o++) begin : g_xor
      assign dout[o] = sum[o] ^ pol[o];
   end

endmodule

// File: rtl/pla_core.sv
module pla_core
   import pla_pkg::*;
#(
   parameter int N_IN   = 3,
   parameter int N_TERM = 4,
   parameter int N_OUT  = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             cfg_shift_en,
   input  logic             cfg_bit,
   input  logic [N_IN-1:0]  din,
   output logic [N_OUT-1:0] dout
);

   localparam int AW  = and_bits(N_IN, N_TERM);
   localparam int OW  = or_bits(N_TERM, N_OUT);
   localparam int LEN = cfg_len(N_IN, N_TERM, N_OUT);

   if (N_IN < 1 || N_IN > 16) begin : g_in_bad
      $error("pla_core: N_IN out of range");
   end
   if (N_TERM < 1 || N_TERM > 64) begin : g_term_bad
      $error("pla_core: N_TERM out of range");
   end
   if (N_OUT < 2 || N_OUT > 32) begin : g_out_bad
      $error("pla_core: N_OUT out of range");
   end

   logic [LEN-1:0]    cfg_q;
   logic [N_TERM-1:0] term;
   logic [N_OUT-1:0]  sum;

   pla_cfg_shift #(.LEN(LEN)) u_cfg (
      .clk      (clk),
      .rst      (rst),
      .shift_en (cfg_shift_en),
      .bit_in   (cfg_bit),
      .cfg_q    (cfg_q)
   );

   pla_and_plane #(.N_IN(N_IN), .N_TERM(N_TERM), .AW(AW)) u_and (
      .x       (din),
      .and_cfg (cfg_q[AW-1:0]),
      .term    (term)
   );

   pla_or_plane #(.N_TERM(N_TERM), .N_OUT(N_OUT), .OW(OW)) u_or (
      .term   (term),
      .or_cfg (cfg_q[AW+OW-1:AW]),
      .sum    (sum)
   );

   pla_pol_stage #(.N_OUT(N_OUT)) u_pol (
      .sum  (sum),
      .pol  (cfg_q[LEN-1:AW+OW]),
      .dout (dout)
   );

endmodule

// File: rtl/pla_core_chk.sv
module pla_core_chk
   import pla_pkg::*;
#(
   parameter int N_IN   = 3,
   parameter int N_TERM = 4,
   parameter int N_OUT  = 2
) (
   input logic                                  clk,
   input logic                                  rst,
   input logic                                  cfg_shift_en,
   input logic                                  cfg_bit,
   input logic [N_OUT-1:0]                      dout,
   input logic [cfg_len(N_IN,N_TERM,N_OUT)-1:0] cfg_q
);

   localparam int AW  = and_bits(N_IN, N_TERM);
   localparam int OW  = or_bits(N_TERM, N_OUT);
   localparam int LEN = cfg_len(N_IN, N_TERM, N_OUT);

   // R1: a cleared configuration drives every output low
   a_r1_clear_out_low: assert property (@(posedge clk) disable iff (rst)
      (cfg_q == '0) |-> (dout == '0));

   // R2: the serial bit enters at the top of the register
   a_r2_bit_enters: assert property (@(posedge clk) disable iff (rst)
      cfg_shift_en |=> (cfg_q[LEN-1] == $past(cfg_bit)));

   // R2: existing bits move one place toward index 0
   a_r2_bits_move: assert property (@(posedge clk) disable iff (rst)
      cfg_shift_en |=> (cfg_q[LEN-2:0] == $past(cfg_q[LEN-1:1])));

   // R3: configuration holds while loading is disabled
   a_r3_hold: assert property (@(posedge clk) disable iff (rst)
      !cfg_shift_en |=> $stable(cfg_q));

   // R7: an output without connected terms shows its polarity bit
   for (genvar o = 0; o < N_OUT; o++) begin : g_empty_out
      a_r7_empty_output: assert property (@(posedge clk) disable iff (rst)
         (cfg_q[AW + o*N_TERM +: N_TERM] == '0) |-> (dout[o] == cfg_q[AW + OW + o]));
   end

endmodule

bind pla_core pla_core_chk #(.N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT)) u_chk (
   .clk          (clk),
   .rst          (rst),
   .cfg_shift_en (cfg_shift_en),
   .cfg_bit      (cfg_bit),
   .dout         (dout),
   .cfg_q        (cfg_q)
);

// File: tb/pla_core_test.sv
module pla_core_test;

   localparam int N_IN   = 3;
   localparam int N_TERM = 4;
   localparam int N_OUT  = 2;
   localparam int AW     = N_IN * 2 * N_TERM;
   localparam int OW     = N_TERM * N_OUT;
   localparam int L      = AW + OW + N_OUT;

   logic             clk = 1'b0;
   logic             rst = 1'b1;
   logic             cfg_shift_en = 1'b0;
   logic             cfg_bit = 1'b0;
   logic [N_IN-1:0]  din = '0;
   logic [N_OUT-1:0] dout;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   pla_core #(.N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT)) uut (
      .clk          (clk),
      .rst          (rst),
      .cfg_shift_en (cfg_shift_en),
      .cfg_bit      (cfg_bit),
      .din          (din),
      .dout         (dout)
   );

   // Bench model written from the requirements (R4..R8).
   function automatic logic [N_OUT-1:0] model(input logic [L-1:0] c, input logic [N_IN-1:0] x);
      logic [N_TERM-1:0] tv;
      logic [N_OUT-1:0]  r;
      for (int t = 0; t < N_TERM; t++) begin
         logic any_lit;
         logic all_ok;
         any_lit = 1'b0;
         all_ok  = 1'b1;
         for (int i = 0; i < N_IN; i++) begin
            if (c[t*2*N_IN + 2*i]) begin
               any_lit = 1'b1;
               if (!x[i]) all_ok = 1'b0;
            end
            if (c[t*2*N_IN + 2*i + 1]) begin
               any_lit = 1'b1;
               if (x[i]) all_ok = 1'b0;
            end
         end
         tv[t] = any_lit & all_ok;
      end
      for (int o = 0; o < N_OUT; o++) begin
         logic s;
         s = 1'b0;
         for (int t = 0; t < N_TERM; t++)
            if (c[AW + o*N_TERM + t] && tv[t]) s = 1'b1;
         r[o] = s ^ c[AW + OW + o];
      end
      return r;
   endfunction

   function automatic logic [L-1:0] set_and(input logic [L-1:0] c, input int t, input int i, input int comp);
      c[t*2*N_IN + 2*i + comp] = 1'b1;
      return c;
   endfunction

   function automatic logic [L-1:0] set_or(input logic [L-1:0] c, input int o, input int t);
      c[AW + o*N_TERM + t] = 1'b1;
      return c;
   endfunction

   function automatic logic [L-1:0] set_pol(input logic [L-1:0] c, input int o);
      c[AW + OW + o] = 1'b1;
      return c;
   endfunction

   task automatic check(input string req, input logic [N_OUT-1:0] act, input logic [N_OUT-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: din=%b dout=%b expected=%b", req, din, act, exp);
      end
   endtask

   task automatic load(input logic [L-1:0] c);
      for (int k = 0; k < L; k++) begin
         @(negedge clk);
         cfg_shift_en = 1'b1;
         cfg_bit      = c[k];
      end
      @(negedge clk);
      cfg_shift_en = 1'b0;
      cfg_bit      = 1'b0;
   endtask

   // Outputs are sampled 1 ns after each input change, away from clock edges (R9).
   task automatic check_all(input string req, input logic [L-1:0] c);
      for (int x = 0; x < (1 << N_IN); x++) begin
         din = x[N_IN-1:0];
         #1;
         check(req, dout, model(c, din));
      end
   endtask

   initial begin
      #(8 * 200000);
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [L-1:0] c;
      logic [63:0]  r64;
      void'($urandom(32'd4711));

      repeat (3) @(negedge clk);
      rst = 1'b0;

      // R1: reset state, all outputs low
      c = '0;
      check_all("R1 reset state", c);

      // R2 R4: first bit is term0/input0/true; term0 -> output0
      c = '0;
      c = set_and(c, 0, 0, 0);
      c = set_or(c, 0, 0);
      load(c);
      check_all("R2 R4 load order", c);
      din = 3'b001; #1; check("R2 out0 follows din[0]", dout, 2'b01);
      din = 3'b110; #1; check("R2 out0 follows din[0]", dout, 2'b00);

      // R5: empty term connected to output0; R7: empty output1 with inversion
      c = '0;
      c = set_or(c, 0, 1);
      c = set_pol(c, 1);
      load(c);
      check_all("R5 R7 empty term and empty output", c);
      din = 3'b111; #1; check("R5 empty term is 0, R7 pol shows", dout, 2'b10);

      // R4: both forms of input1 in one term -> term always 0
      c = '0;
      c = set_and(c, 2, 1, 0);
      c = set_and(c, 2, 1, 1);
      c = set_or(c, 0, 2);
      c = set_or(c, 1, 2);
      load(c);
      check_all("R4 contradictory literals", c);

      // R6 R8: 3-input parity on output0, its complement on output1 sharing all terms
      c = '0;
      begin
         int mt [4] = '{1, 2, 4, 7};
         for (int t = 0; t < 4; t++) begin
            for (int i = 0; i < N_IN; i++)
               c = set_and(c, t, i, mt[t][i] ? 0 : 1);
            c = set_or(c, 0, t);
            c = set_or(c, 1, t);
         end
      end
      c = set_pol(c, 1);
      load(c);
      for (int x = 0; x < 8; x++) begin
         logic p;
         din = x[2:0];
         #1;
         p = ^din;
         check("R6 R8 parity pair", dout, {~p, p});
      end

      // R3: enable low, cfg_bit toggling, mapping unchanged
      for (int k = 0; k < 12; k++) begin
         @(negedge clk);
         cfg_bit = ~cfg_bit;
      end
      cfg_bit = 1'b0;
      check_all("R3 hold while disabled", c);

      // R1: reset mid-run clears the loaded configuration
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
      check_all("R1 reset after load", '0);

      // R4 R6 R8 R9: seeded random configurations
      for (int n = 0; n < 30; n++) begin
         r64 = {$urandom(), $urandom()};
         c = r64[L-1:0];
         load(c);
         check_all("R4 R6 R8 R9 random config", c);
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule